// File: doc/BRIEF.md
# PRBS7 Link Self-Test Checker

This block sits on the receive side of a serial video link and checks the recovered pixel payloads during a link self-test. While the test-enable input is high, each valid 24-bit payload word is compared against the next 24 bits of a locally produced PRBS7 sequence, at one word per pixel clock. The pass output drops for one clock for every payload that holds at least one wrong bit. Once the test ends, the pass output holds the overall verdict.

The checker has no fixed phase relation to the far-end generator. After each start it spends a fixed number of valid words loading its shift register from the received stream. From then on it predicts every word from its own state, so a corrupted word is counted once and does not throw the following compares out of step. A saturating counter reports how many errored payloads the current test has seen. A small PRBS7 word source (`prbs7_src`) is part of the project so that a bench can drive the checker from a pattern generator of the same form.

Top module: `lnk_bist_chk`

## Requirements
- R1: While `rst` or `pwr_dn` is high at a clock edge, `pass_o` becomes 1 and `err_cnt_o` becomes 0 after that edge, and any held result is discarded.
- R2: The pattern follows x^7 + x^6 + 1. Each word carries 24 sequence bits with bit 23 the oldest, and every sequence bit equals the XOR of the bits 7 and 6 places before it. A stream that obeys this is never flagged.
- R3: The first LOCK_WORDS valid words after a start only load the checker and are never flagged. The state is taken from bits [6:0] of the last of them, so errors anywhere else in those words have no effect.
- R4: A checked word with anywhere from 1 to 24 wrong bits counts as exactly one errored payload. `pass_o` is 0 for the single clock that follows the edge that took that word.
- R5: After an errored word, checking continues from the predicted sequence and not from the received bits, so later clean words match again.
- R6: `err_cnt_o` rises by one per errored payload and stops at 2^CNT_W-1 without wrapping.
- R7: A start (`test_en` sampled high after being sampled low) clears the counter and the held result, and `pass_o` is 1 after that edge.
- R8: A cycle with `pay_vld` low neither checks a word nor advances the expected sequence.
- R9: While `test_en` is low, payloads are ignored, `err_cnt_o` holds, and `pass_o` holds 1 if the last test saw no errored payload and 0 if it saw one or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dn | input | 1 | Synchronous active-high power-down; clears like reset |
| test_en | input | 1 | Self-test window; the test runs while high |
| pay_vld | input | 1 | Payload word valid this cycle |
| payload | input | 24 | Received payload bits, bit 23 oldest |
| pass_o | output | 1 | Per-error low pulse during a test, held verdict afterwards |
| err_cnt_o | output | 16 | Saturating count of errored payloads in the current test |

## Verification
The bench starts a test at an arbitrary phase of the source and corrupts the first seed word completely. A checker that seeded from the wrong bits, or that checked during lock, would count errors on a clean stream. It injects single-bit, all-bit and top-bit errors separated by clean words. A design that resynchronised from the received bits would count extra errors after each one, and one that compared only some bits would miss the single-bit case. It also drives errored words while enable is low, interleaves invalid cycles carrying garbage, pushes the counter past its limit, and clears the held result with power-down and with reset. These catch a counter that wraps, a sequence that advances on invalid cycles, and a verdict that does not stick or does not clear.

// File: rtl/lnk_bist_pkg.sv
package lnk_bist_pkg;
  localparam int PRBS_W     = 7;
  localparam int TAP_HI     = 6;
  localparam int TAP_LO     = 5;
  localparam int DEF_WORD_W = 24;
  localparam int DEF_CNT_W  = 16;
  localparam int DEF_LOCK   = 2;
endpackage

// File: rtl/prbs7_word.sv
module prbs7_word
  import lnk_bist_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W
) (
  input  logic [PRBS_W-1:0] state_i,
  output logic [WORD_W-1:0] word_o,
  output logic [PRBS_W-1:0] next_o
);
  logic [PRBS_W-1:0] chain [0:WORD_W];

  assign chain[0] = state_i;

  // one LFSR step per bit; the first bit produced lands in the top position
  for (genvar k = 0; k < WORD_W; k++) begin : g_step
    logic fb;
    assign fb             = chain[k][TAP_HI] ^ chain[k][TAP_LO];
    assign chain[k+1]     = {chain[k][PRBS_W-2:0], fb};
    assign word_o[WORD_W-1-k] = fb;
  end

  assign next_o = chain[WORD_W];
endmodule

// File: rtl/prbs7_src.sv
module prbs7_src
  import lnk_bist_pkg::*;
#(
  parameter int              WORD_W = DEF_WORD_W,
  parameter logic [PRBS_W-1:0] SEED = 7'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  output logic [WORD_W-1:0] word_o
);
  logic [PRBS_W-1:0] st_q;
  logic [PRBS_W-1:0] st_nxt;

  prbs7_word #(.WORD_W(WORD_W)) u_word (
    .state_i (st_q),
    .word_o  (word_o),
    .next_o  (st_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)         st_q <= SEED;
    else if (step_i) st_q <= st_nxt;
  end
endmodule

// File: rtl/bist_seed_ctl.sv
module bist_seed_ctl
  import lnk_bist_pkg::*;
#(
  parameter int LOCK_WORDS = DEF_LOCK
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              test_en,
  input  logic              pay_vld,
  input  logic [PRBS_W-1:0] seed_i,
  input  logic [PRBS_W-1:0] adv_i,
  output logic              start_o,
  output logic              chk_o,
  output logic [PRBS_W-1:0] state_o
);
  localparam int LCW = $clog2(LOCK_WORDS + 1);

  logic           en_q;
  logic [LCW-1:0] lock_q;
  logic [LCW-1:0] lock_eff;
  logic           seeding;

  assign start_o  = test_en & ~en_q;
  assign lock_eff = start_o ? LCW'(LOCK_WORDS) : lock_q;
  assign seeding  = test_en & pay_vld & (lock_eff != '0);
  assign chk_o    = test_en & pay_vld & (lock_eff == '0);

  always_ff @(posedge clk) begin
    if (clr) begin
      en_q    <= 1'b0;
      lock_q  <= '0;
      state_o <= '1;
    end else begin
      en_q <= test_en;
      if (seeding) begin
        state_o <= seed_i;
        lock_q  <= lock_eff - LCW'(1);
      end else if (start_o) begin
        lock_q <= LCW'(LOCK_WORDS);
      end else if (chk_o) begin
        state_o <= adv_i;
      end
    end
  end
endmodule

// File: rtl/lnk_bist_chk.sv
module lnk_bist_chk
  import lnk_bist_pkg::*;
#(
  parameter int WORD_W     = DEF_WORD_W,
  parameter int CNT_W      = DEF_CNT_W,
  parameter int LOCK_WORDS = DEF_LOCK
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_dn,
  input  logic              test_en,
  input  logic              pay_vld,
  input  logic [WORD_W-1:0] payload,
  output logic              pass_o,
  output logic [CNT_W-1:0]  err_cnt_o
);
  logic              clr;
  logic              start;
  logic              chk;
  logic              mism;
  logic              seen_q;
  logic [PRBS_W-1:0] state;
  logic [PRBS_W-1:0] adv;
  logic [WORD_W-1:0] exp_word;
  logic [CNT_W-1:0]  cnt_base;

  assign clr = rst | pwr_dn;

  bist_seed_ctl #(.LOCK_WORDS(LOCK_WORDS)) u_seed (
    .clk     (clk),
    .clr     (clr),
    .test_en (test_en),
    .pay_vld (pay_vld),
    .seed_i  (payload[PRBS_W-1:0]),
    .adv_i   (adv),
    .start_o (start),
    .chk_o   (chk),
    .state_o (state)
  );

  prbs7_word #(.WORD_W(WORD_W)) u_pred (
    .state_i (state),
    .word_o  (exp_word),
    .next_o  (adv)
  );

  assign mism     = chk & (payload != exp_word);
  assign cnt_base = start ? '0 : err_cnt_o;

  always_ff @(posedge clk) begin
    if (clr) begin
      pass_o    <= 1'b1;
      err_cnt_o <= '0;
      seen_q    <= 1'b0;
    end else begin
      if (mism) begin
        err_cnt_o <= (cnt_base == '1) ? cnt_base : cnt_base + CNT_W'(1);
        seen_q    <= 1'b1;
      end else if (start) begin
        err_cnt_o <= '0;
        seen_q    <= 1'b0;
      end
      pass_o <= test_en ? ~mism : ~seen_q;
    end
  end
endmodule

// File: rtl/lnk_bist_chk_sva.sv
module lnk_bist_chk_sva #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             pwr_dn,
  input logic             test_en,
  input logic             pass_o,
  input logic [CNT_W-1:0] err_cnt_o
);
  // R1
  clear_state_chk: assert property (@(posedge clk)
    (rst || pwr_dn) |=> (pass_o && err_cnt_o == '0));

  // R4
  low_pass_has_count_chk: assert property (@(posedge clk) disable iff (rst || pwr_dn)
    !pass_o |-> err_cnt_o != '0);

  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst || pwr_dn)
    ($past(err_cnt_o) == '1 && $past(test_en) && $past(test_en, 2)) |-> err_cnt_o == '1);

  // R6
  count_monotonic_chk: assert property (@(posedge clk) disable iff (rst || pwr_dn)
    ($past(test_en) && $past(test_en, 2)) |-> err_cnt_o >= $past(err_cnt_o));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst || pwr_dn)
    (!test_en && !$past(test_en) && !$past(test_en, 2)) |-> ($stable(pass_o) && $stable(err_cnt_o)));
endmodule

bind lnk_bist_chk lnk_bist_chk_sva #(.CNT_W(CNT_W)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .pwr_dn    (pwr_dn),
  .test_en   (test_en),
  .pass_o    (pass_o),
  .err_cnt_o (err_cnt_o)
);

// File: tb/lnk_bist_chk_bench.sv
module lnk_bist_chk_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 24;
  localparam int CW         = 4;
  localparam int LOCKN      = 2;
  localparam int MAXC       = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pwr_dn = 1'b0;
  logic          test_en = 1'b0;
  logic          pay_vld = 1'b0;
  logic          step = 1'b0;
  logic [W-1:0]  payload = '0;
  logic [W-1:0]  src_w;
  logic          pass_o;
  logic [CW-1:0] err_cnt_o;

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  string cur_req = "R1";

  // reference model state
  bit    m_pass = 1'b1;
  int    m_cnt  = 0;
  bit    m_seen = 1'b0;
  bit    m_en_q = 1'b0;
  int    m_lock = 0;
  bit    hist[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  prbs7_src #(.WORD_W(W), .SEED(7'h2B)) u_src (
    .clk (clk), .rst (rst), .step_i (step), .word_o (src_w)
  );

  lnk_bist_chk #(.WORD_W(W), .CNT_W(CW), .LOCK_WORDS(LOCKN)) u_lnk_bist_chk (
    .clk (clk), .rst (rst), .pwr_dn (pwr_dn), .test_en (test_en),
    .pay_vld (pay_vld), .payload (payload), .pass_o (pass_o), .err_cnt_o (err_cnt_o)
  );

  always @(posedge clk) begin
    bit start, mism, e;
    if (rst || pwr_dn) begin
      m_pass = 1; m_cnt = 0; m_seen = 0; m_en_q = 0; m_lock = 0;
    end else begin
      start = test_en && !m_en_q;
      if (start) begin m_cnt = 0; m_seen = 0; m_lock = LOCKN; end
      if (test_en && pay_vld) begin
        if (m_lock > 0) begin
          hist.delete();
          for (int k = W-1; k >= 0; k--) begin
            hist.push_back(payload[k]);
            if (hist.size() > 7) void'(hist.pop_front());
          end
          m_lock--;
          m_pass = 1;
        end else begin
          mism = 0;
          for (int k = W-1; k >= 0; k--) begin
            e = hist[0] ^ hist[1];
            hist.push_back(e);
            void'(hist.pop_front());
            if (payload[k] != e) mism = 1;
          end
          if (mism) begin
            if (m_cnt < MAXC) m_cnt++;
            m_seen = 1;
          end
          m_pass = !mism;
        end
      end else if (test_en) begin
        m_pass = 1;
      end else begin
        m_pass = !m_seen;
      end
      m_en_q = test_en;
    end
  end

  always @(negedge clk) begin
    checks++;
    if (pass_o !== m_pass) begin
      fails++;
      $display("FAIL %s pass_o actual=%b expected=%b at cycle %0d", cur_req, pass_o, m_pass, cyc);
    end
    checks++;
    if (err_cnt_o !== CW'(m_cnt)) begin
      fails++;
      $display("FAIL %s err_cnt_o actual=%0d expected=%0d at cycle %0d", cur_req, err_cnt_o, m_cnt, cyc);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic send(input logic [W-1:0] mask);
    @(negedge clk);
    payload = src_w ^ mask;
    pay_vld = 1'b1;
    step    = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      payload = W'($urandom);
      pay_vld = 1'b0;
      step    = 1'b0;
    end
  endtask

  task automatic clean(input int n);
    for (int i = 0; i < n; i++) send('0);
  endtask

  task automatic set_en(input logic v);
    @(negedge clk);
    test_en = v;
    pay_vld = 1'b0;
    step    = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic p, input int c);
    @(negedge clk);
    #1;
    checks++;
    if (pass_o !== p || err_cnt_o !== CW'(c)) begin
      fails++;
      $display("FAIL %s explicit pass=%b cnt=%0d expected pass=%b cnt=%0d", req, pass_o, err_cnt_o, p, c);
    end
  endtask

  initial begin
    // R1: reset state
    cur_req = "R1";
    idle(5);
    @(negedge clk); rst = 1'b0;
    expect_out("R1", 1'b1, 0);

    // R2, R8: clean stream with invalid cycles interleaved
    cur_req = "R2";
    set_en(1'b1);
    clean(LOCKN);
    for (int i = 0; i < 12; i++) begin
      send('0);
      if (i % 3 == 0) begin cur_req = "R8"; idle(2); cur_req = "R2"; end
    end
    idle(1);
    set_en(1'b0);
    cur_req = "R9";
    idle(3);
    expect_out("R9", 1'b1, 0);

    // R4, R5: errored payloads of different weights
    cur_req = "R4";
    set_en(1'b1);
    clean(LOCKN);
    clean(4);
    send(24'h000001);
    cur_req = "R5";
    clean(3);
    cur_req = "R4";
    send(24'hFFFFFF);
    clean(2);
    send(24'h800000);
    cur_req = "R5";
    clean(4);
    idle(1);
    expect_out("R4", 1'b1, 3);
    set_en(1'b0);

    // R9: words while disabled are ignored; verdict held low
    cur_req = "R9";
    idle(2);
    for (int i = 0; i < 5; i++) send(24'h00F00F);
    idle(3);
    expect_out("R9", 1'b0, 3);

    // R7, R3: restart at a new phase with a wholly corrupted first seed word
    cur_req = "R7";
    set_en(1'b1);
    expect_out("R7", 1'b1, 0);
    cur_req = "R3";
    send(24'hFFFFFF);
    send(24'hABC000);
    clean(10);
    idle(1);
    expect_out("R3", 1'b1, 0);

    // R6: saturation
    cur_req = "R6";
    for (int i = 0; i < MAXC + 5; i++) send(24'h000100);
    idle(2);
    expect_out("R6", 1'b1, MAXC);
    set_en(1'b0);
    idle(3);
    expect_out("R6", 1'b0, MAXC);

    // R1: power-down clears held verdict
    cur_req = "R1";
    @(negedge clk); pwr_dn = 1'b1;
    idle(2);
    @(negedge clk); pwr_dn = 1'b0;
    expect_out("R1", 1'b1, 0);

    // R1: reset clears a held failing verdict
    set_en(1'b1);
    clean(LOCKN);
    send(24'h0000F0);
    clean(2);
    set_en(1'b0);
    idle(2);
    expect_out("R1", 1'b0, 1);
    @(negedge clk); rst = 1'b1;
    idle(2);
    @(negedge clk); rst = 1'b0;
    expect_out("R1", 1'b1, 0);
    idle(3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule